// File: doc/BRIEF.md
# BCD Month-Day Calendar Counter

This block keeps the current calendar date as four BCD digits: month tens, month units, day tens and day units. Each single-cycle advance pulse, normally driven by the time-of-day counter when it wraps past midnight, moves the date on by one day. The block decodes the month pair to find that month's last day. An advance on the last day restarts the day at 01 and steps the month. An advance on December 31 returns the date to January 1 and raises a one-cycle year-carry pulse, which a year counter outside the block can use. Leap years are not handled, so February always has 28 days.

A synchronous load writes a starting date, given as two BCD pairs. Load has priority over an advance in the same cycle. The update is organised as a small decoded step machine. Every cycle selects exactly one step, and that step decides the next date register value:

- HOLD: no pulse, so the date stays as it is.
- LOAD: the load pair is copied into the date.
- NEXT_DAY: advance in mid-month, so the day digits increment.
- NEXT_MONTH: advance on the last day of months 01 to 11, so the day restarts at 01 and the month increments.
- NEXT_YEAR: advance on 12/31, so the date becomes 01/01 and the year-carry pulse is raised.

The transitions are these. LOAD is taken whenever the load input is high. Otherwise NEXT_YEAR, NEXT_MONTH or NEXT_DAY is taken when the advance input is high, chosen by the month-end decode. HOLD is taken in every other cycle.

Top module: `cal_date_counter`

## Requirements
- R1: After reset the date reads month 01, day 01 (month tens 0, month units 1, day tens 0, day units 1), and year carry is low.
- R2: When load is high at a clock edge, the date takes the load inputs (month tens in bits 7:4 of the month pair, units in 3:0; the day pair has the same layout). This holds even if advance is high in the same cycle, and year carry stays low.
- R3: In a cycle with neither load nor advance, the date does not change and year carry is low.
- R4: An advance before the month's last day increments the day. Day units roll from 9 to 0 and carry into day tens, so 01/09 becomes 01/10.
- R5: In month 02, the advance from day 28 gives 03/01.
- R6: In months 04, 06, 09 and 11, the advance from day 30 gives day 01 of the next month. Day 30 is never followed by 31 in these months.
- R7: In months 01, 03, 05, 07, 08, 10 and 12, day 30 advances to 31, and the advance from day 31 ends the month.
- R8: The month units digit rolls from 9 to 0 and carries into month tens, so 09/30 advances to 10/01.
- R9: The advance from 12/31 gives 01/01, and year carry is high for exactly the one cycle after that edge. Year carry is low after every other step.
- R10: After any sequence of advances from a valid date, the month stays in 01 to 12 and the day is never 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | One-cycle pulse that advances the date by one day |
| load_i | input | 1 | Synchronous load strobe |
| load_month_i | input | 8 | BCD month to load: tens in 7:4, units in 3:0 |
| load_day_i | input | 8 | BCD day to load: tens in 7:4, units in 3:0 |
| mon_tens_o | output | 4 | Month tens digit |
| mon_units_o | output | 4 | Month units digit |
| day_tens_o | output | 4 | Day tens digit |
| day_units_o | output | 4 | Day units digit |
| year_carry_o | output | 1 | One-cycle pulse after the wrap from December 31 |

## Verification
Some properties are checked by assertions on every cycle:

- The date holds in idle cycles.
- The year carry is a one-cycle pulse that only coincides with 01/01.
- The month stays in 01 to 12, and the day is never 00.
- The February 28 wrap goes to 03/01.
- A load overrides an advance.

The length of each month, the BCD carries at 09 and 19, and the full order of dates through a year can only be shown by the bench scenarios. These are the directed month-end cases and a whole-year walk that is compared against a model of month lengths computed from integers.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DIGIT_W = 4;
    localparam int PAIR_W  = 2 * DIGIT_W;

    typedef struct packed {
        logic [DIGIT_W-1:0] mt;
        logic [DIGIT_W-1:0] mu;
        logic [DIGIT_W-1:0] dt;
        logic [DIGIT_W-1:0] du;
    } cal_date_t;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LOAD,
        ST_NEXT_DAY,
        ST_NEXT_MONTH,
        ST_NEXT_YEAR
    } step_e;
endpackage

// File: rtl/cal_bcd_inc.sv
module cal_bcd_inc #(
    parameter int W = 4
) (
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         co
);
    localparam logic [W-1:0] TOP = W'(9);

    always_comb begin
        co = (d == TOP);
        q  = co ? '0 : d + W'(1);
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
    parameter int W = 4
) (
    input  logic [W-1:0] mt,
    input  logic [W-1:0] mu,
    output logic [W-1:0] last_dt,
    output logic [W-1:0] last_du
);
    always_comb begin
        last_dt = W'(3);
        last_du = W'(1);
        if (mt == W'(0) && mu == W'(2)) begin
            last_dt = W'(2);
            last_du = W'(8);
        end else if ((mt == W'(0) && (mu == W'(4) || mu == W'(6) || mu == W'(9))) ||
                     (mt == W'(1) && mu == W'(1))) begin
            last_dt = W'(3);
            last_du = W'(0);
        end
    end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              load_i,
    input  logic [PAIR_W-1:0] load_month_i,
    input  logic [PAIR_W-1:0] load_day_i,
    output logic [DIGIT_W-1:0] mon_tens_o,
    output logic [DIGIT_W-1:0] mon_units_o,
    output logic [DIGIT_W-1:0] day_tens_o,
    output logic [DIGIT_W-1:0] day_units_o,
    output logic               year_carry_o
);
    localparam int NUM_INC = 2;
    localparam logic [DIGIT_W-1:0] ZERO = '0;
    localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

    cal_date_t date_q, date_nx;
    step_e     step;
    logic      carry_q;

    logic [DIGIT_W-1:0] last_dt, last_du;
    logic               at_end, is_dec;

    logic [NUM_INC-1:0][DIGIT_W-1:0] inc_in, inc_out;
    logic [NUM_INC-1:0]              inc_co;

    assign inc_in[0] = date_q.du;
    assign inc_in[1] = date_q.mu;

    for (genvar g = 0; g < NUM_INC; g++) begin : g_inc
        cal_bcd_inc #(.W(DIGIT_W)) inc_i (
            .d  (inc_in[g]),
            .q  (inc_out[g]),
            .co (inc_co[g])
        );
    end

    cal_month_len #(.W(DIGIT_W)) len_i (
        .mt      (date_q.mt),
        .mu      (date_q.mu),
        .last_dt (last_dt),
        .last_du (last_du)
    );

    assign at_end = (date_q.dt == last_dt) && (date_q.du == last_du);
    assign is_dec = (date_q.mt == ONE) && (date_q.mu == DIGIT_W'(2));

    // Step decode
    always_comb begin
        step = ST_HOLD;
        if (load_i) begin
            step = ST_LOAD;
        end else if (adv_i) begin
            if (!at_end)     step = ST_NEXT_DAY;
            else if (is_dec) step = ST_NEXT_YEAR;
            else             step = ST_NEXT_MONTH;
        end
    end

    // Next-date output logic
    always_comb begin
        date_nx = date_q;
        unique case (step)
            ST_HOLD: ;
            ST_LOAD: begin
                date_nx.mt = load_month_i[PAIR_W-1:DIGIT_W];
                date_nx.mu = load_month_i[DIGIT_W-1:0];
                date_nx.dt = load_day_i[PAIR_W-1:DIGIT_W];
                date_nx.du = load_day_i[DIGIT_W-1:0];
            end
            ST_NEXT_DAY: begin
                date_nx.du = inc_out[0];
                if (inc_co[0]) date_nx.dt = date_q.dt + ONE;
            end
            ST_NEXT_MONTH: begin
                date_nx.dt = ZERO;
                date_nx.du = ONE;
                date_nx.mu = inc_out[1];
                if (inc_co[1]) date_nx.mt = date_q.mt + ONE;
            end
            ST_NEXT_YEAR: begin
                date_nx.mt = ZERO;
                date_nx.mu = ONE;
                date_nx.dt = ZERO;
                date_nx.du = ONE;
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q  <= '{mt: ZERO, mu: ONE, dt: ZERO, du: ONE};
            carry_q <= 1'b0;
        end else begin
            date_q  <= date_nx;
            carry_q <= (step == ST_NEXT_YEAR);
        end
    end

    assign mon_tens_o   = date_q.mt;
    assign mon_units_o  = date_q.mu;
    assign day_tens_o   = date_q.dt;
    assign day_units_o  = date_q.du;
    assign year_carry_o = carry_q;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(date_q) && !year_carry_o));

    // R9
    carry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        year_carry_o |=> !year_carry_o);

    // R9
    carry_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
        year_carry_o |-> (date_q.mt == ZERO && date_q.mu == ONE &&
                          date_q.dt == ZERO && date_q.du == ONE));

    // R10
    day_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(date_q.dt == ZERO && date_q.du == ZERO));

    // R10
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({date_q.mt, date_q.mu} >= 8'h01) && ({date_q.mt, date_q.mu} <= 8'h12));

    // R5
    feb_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && date_q == '{mt: ZERO, mu: 4'd2, dt: 4'd2, du: 4'd8})
        |=> (date_q == '{mt: ZERO, mu: 4'd3, dt: ZERO, du: ONE}));

    // R2
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ({date_q.mt, date_q.mu} == $past(load_month_i) &&
                    {date_q.dt, date_q.du} == $past(load_day_i) && !year_carry_o));
endmodule

// File: tb/cal_date_counter_tb_top.sv
module cal_date_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] load_month_i = 8'h00;
    logic [7:0] load_day_i = 8'h00;
    logic [3:0] mon_tens_o, mon_units_o, day_tens_o, day_units_o;
    logic       year_carry_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cal_date_counter dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .load_i(load_i),
        .load_month_i(load_month_i), .load_day_i(load_day_i),
        .mon_tens_o(mon_tens_o), .mon_units_o(mon_units_o),
        .day_tens_o(day_tens_o), .day_units_o(day_units_o),
        .year_carry_o(year_carry_o)
    );

    function automatic logic [7:0] bcd8(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mlen(input int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int m, input int d, input bit yc);
        logic [16:0] act, exp;
        act = {mon_tens_o, mon_units_o, day_tens_o, day_units_o, year_carry_o};
        exp = {bcd8(m), bcd8(d), yc};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual mm/dd/yc=%h/%h/%b expected %h/%h/%b", req,
                     act[16:9], act[8:1], act[0], exp[16:9], exp[8:1], exp[0]);
        end
    endtask

    task automatic load_date(input int m, input int d, input bit with_adv);
        @(negedge clk);
        load_i = 1'b1; adv_i = with_adv;
        load_month_i = bcd8(m); load_day_i = bcd8(d);
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
    endtask

    task automatic advance;
        @(negedge clk);
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
    endtask

    task automatic test_reset;
        chk("R1", 1, 1, 0);
    endtask

    task automatic test_load;
        load_date(7, 15, 0);
        chk("R2", 7, 15, 0);
        load_date(3, 9, 1);
        chk("R2", 3, 9, 0);
    endtask

    task automatic test_hold;
        load_date(5, 20, 0);
        repeat (5) @(negedge clk);
        chk("R3", 5, 20, 0);
    endtask

    task automatic test_day_carry;
        load_date(1, 9, 0);
        advance(); chk("R4", 1, 10, 0);
        load_date(1, 19, 0);
        advance(); chk("R4", 1, 20, 0);
        load_date(12, 28, 0);
        advance(); chk("R4", 12, 29, 0);
    endtask

    task automatic test_feb;
        load_date(2, 28, 0);
        advance(); chk("R5", 3, 1, 0);
    endtask

    task automatic test_thirty;
        int ms[4] = '{4, 6, 9, 11};
        foreach (ms[i]) begin
            load_date(ms[i], 30, 0);
            advance();
            chk("R6", ms[i] + 1, 1, 0);
        end
    endtask

    task automatic test_thirty_one;
        load_date(1, 30, 0);
        advance(); chk("R7", 1, 31, 0);
        advance(); chk("R7", 2, 1, 0);
        load_date(8, 31, 0);
        advance(); chk("R7", 9, 1, 0);
    endtask

    task automatic test_month_carry;
        load_date(9, 30, 0);
        advance(); chk("R8", 10, 1, 0);
    endtask

    task automatic test_year;
        load_date(12, 31, 0);
        advance(); chk("R9", 1, 1, 1);
        @(negedge clk); chk("R9", 1, 1, 0);
    endtask

    task automatic test_walk;
        int m = 1, d = 1;
        bit yc;
        load_date(1, 1, 0);
        for (int k = 0; k < 365; k++) begin
            yc = 0;
            if (d == mlen(m)) begin
                d = 1;
                if (m == 12) begin m = 1; yc = 1; end
                else m++;
            end else d++;
            advance();
            chk("R10", m, d, yc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load();
        test_hold();
        test_day_carry();
        test_feb();
        test_thirty();
        test_thirty_one();
        test_month_carry();
        test_year();
        test_walk();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule